// File: doc/BRIEF.md
# Four-Bank SDRAM Command Scheduler

This block turns simple memory requests into a legal command stream for one rank of registered SDRAM with four independent banks. A front end presents one request at a time with a valid/ready handshake. A request is a read, a write, an explicit precharge (one bank or all banks) or a refresh. The scheduler keeps track of which row is open in each bank, and it runs a set of down-counters for each bank and for the whole rank. It drives chip-select, RAS, CAS, WE, the bank pins and the address pins from registers, so each command appears on the pins one clock after the scheduler decides to issue it.

A read or write that hits the open row goes out as a single column command. A request to a different row first closes the bank and then opens the new row. After reset the block issues one mode-register load with a fixed word and waits the required gap before the first activate. A free-running interval counter raises auto-refresh on its own schedule. A pending refresh outranks reads and writes. Before a refresh, any open rows are closed with a precharge-all.

The default clock counts suit CAS latency 4 at 133 MHz. Every spacing is a parameter.

Top module: `sdram_cmd_sched`

## Requirements
- R1: After reset the first command is a mode-register load, with `addr` equal to `MODE_WORD` and `ba` = 00. No activate follows it sooner than `T_MRD` clocks later.
- R2: Commands are encoded on (`csN`,`rasN`,`casN`,`weN`) as follows: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000. In a cycle with no command, `csN` = 1. During reset all four pins are 1.
- R3: Bank index k is driven as `ba[1]` = k[0] and `ba[0]` = k[1`]`. So bank 1 gives `ba` = 10, bank 2 gives 01, bank 0 gives 00 and bank 3 gives 11.
- R4: An activate drives the row on `addr[12:0]`. A read or write drives column bits 9..0 on `addr[9:0]` and column bit 10 on `addr[11]`, with `addr[10]` = 0 and `addr[12]` = 0.
- R5: A read or write whose row is already open in its bank goes out as the column command alone, with no precharge or activate before it.
- R6: A read or write to a closed bank issues an activate and then the column command. If another row is open in that bank, a single-bank precharge (`addr[10]` = 0) comes first. Column commands only go to an open bank.
- R7: Spacing within one bank, in clocks: activate to column ≥ `T_RCD` (3), activate to precharge ≥ `T_RAS` (6), precharge to activate ≥ `T_RP` (3), activate to activate ≥ `T_RC` (9), write to precharge ≥ `T_WR` (1).
- R8: Activates to different banks are ≥ `T_RRD` (2) clocks apart. Refresh to activate and refresh to refresh are each ≥ `T_RC` clocks.
- R9: A refresh is issued at least once every `REF_INT` clocks, plus a short drain delay. A refresh is issued only while all banks are closed, and a precharge-all (`addr[10]` = 1) closes any open rows first.
- R10: A refresh that has fallen due is issued ahead of pending read and write requests, so the bound in R9 holds under continuous read traffic.
- R11: A precharge request (`reqOp` = 2) drives `addr[10]` equal to `reqAll`. A single-bank precharge leaves the other banks' rows open. A precharge-all closes every bank.
- R12: A refresh request (`reqOp` = 3) is acknowledged when its refresh command is issued. A precharge-all precedes the refresh if any row is open.
- R13: Read or write hits to an open row may be accepted, and issued, on consecutive clocks.

Request opcodes on `reqOp`: 0 read, 1 write, 2 precharge, 3 refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this clock |
| reqOp | input | 2 | Opcode: 0 read, 1 write, 2 precharge, 3 refresh |
| reqBank | input | 2 | Bank index 0..3 |
| reqRow | input | 13 | Row for read or write |
| reqCol | input | 11 | Column for read or write |
| reqAll | input | 1 | Precharge applies to all banks |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank pins |
| addr | output | 13 | Address pins |

## Verification
Reads and writes are driven in three patterns, each checked against the pins it produces:
- to a closed bank, which must show an activate and then the column command;
- to the open row, which must show no row command at all;
- to another row, which must show a single-bank precharge, an activate and then the column command.

Requests to each of the four banks tell the crossed bank-pin mapping apart from a straight one. Back-to-back hits confirm that column commands can go out on consecutive clocks.

Every command on the pins is timestamped and checked against the same-bank, cross-bank, refresh and mode-load spacing rules. This covers an idle stretch, where refresh must follow its interval, and a stretch of continuous reads, where a due refresh must still get through.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  localparam int BANK_W = 2;
  localparam int NBANK  = 4;

  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_PRE = 2'd2, OP_REF = 2'd3} op_e;

  // one-cycle command strobes from control to the bank-state datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic refr;
    logic mrs;
    logic [BANK_W-1:0] bank;
  } strobe_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sched_bank_timers.sv
`timescale 1ns/1ps
module sched_bank_timers
  import sched_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_RRD   = 2,
  parameter int T_WR    = 1,
  parameter int T_MRD   = 1,
  parameter int REF_INT = 1039
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [ROW_W-1:0] reqRow,
  output logic [NBANK-1:0] bankOpen,
  output logic [NBANK-1:0] rowHit,
  output logic [NBANK-1:0] colOk,
  output logic [NBANK-1:0] preOk,
  output logic [NBANK-1:0] actOk,
  output logic             rrdOk,
  output logic             refDue
);
  localparam int TMAX = imax(imax(imax(T_RCD, T_RAS), imax(T_RP, T_RC)),
                             imax(imax(T_RRD, T_WR), T_MRD));
  localparam int CW = $clog2(TMAX + 1);
  localparam int RW = $clog2(REF_INT + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t L_RCD = cnt_t'(T_RCD - 1);
  localparam cnt_t L_RAS = cnt_t'(T_RAS - 1);
  localparam cnt_t L_RP  = cnt_t'(T_RP - 1);
  localparam cnt_t L_RC  = cnt_t'(T_RC - 1);
  localparam cnt_t L_RRD = cnt_t'(T_RRD - 1);
  localparam cnt_t L_WR  = cnt_t'(T_WR - 1);
  localparam cnt_t L_MRD = cnt_t'(T_MRD - 1);

  function automatic cnt_t dec(input cnt_t x);
    return (x == '0) ? '0 : x - cnt_t'(1);
  endfunction
  function automatic cnt_t cmax(input cnt_t a, input cnt_t b);
    return (a > b) ? a : b;
  endfunction

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    cnt_t colW, preW, actW;
    logic isOpen;
    logic [ROW_W-1:0] openRow;
    logic sel, closeIt;
    assign sel     = (stb.bank == BANK_W'(g));
    assign closeIt = stb.pre && (stb.preAll || sel);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        colW <= '0; preW <= '0; actW <= '0;
        isOpen <= 1'b0; openRow <= '0;
      end else begin
        colW <= (stb.act && sel) ? L_RCD : dec(colW);
        if (stb.act && sel)      preW <= L_RAS;
        else if (stb.wr && sel)  preW <= cmax(dec(preW), L_WR);
        else                     preW <= dec(preW);
        if (stb.refr)            actW <= L_RC;
        else if (stb.mrs)        actW <= L_MRD;
        else if (stb.act && sel) actW <= L_RC;
        else if (closeIt)        actW <= cmax(dec(actW), L_RP);
        else                     actW <= dec(actW);
        if (stb.act && sel) begin
          isOpen  <= 1'b1;
          openRow <= reqRow;
        end else if (closeIt) begin
          isOpen <= 1'b0;
        end
      end
    end

    assign bankOpen[g] = isOpen;
    assign rowHit[g]   = isOpen && (openRow == reqRow);
    assign colOk[g]    = (colW == '0);
    assign preOk[g]    = (preW == '0);
    assign actOk[g]    = (actW == '0);
  end

  cnt_t rrdW;
  logic [RW-1:0] refCnt;
  logic refPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdW <= '0; refCnt <= '0; refPend <= 1'b0;
    end else begin
      rrdW <= stb.act ? L_RRD : dec(rrdW);
      if (refCnt == RW'(REF_INT - 1)) begin
        refCnt  <= '0;
        refPend <= 1'b1;
      end else begin
        refCnt <= refCnt + RW'(1);
        if (stb.refr) refPend <= 1'b0;
      end
    end
  end

  assign rrdOk  = (rrdW == '0);
  assign refDue = refPend;

  // R6: column command only to an open bank
  p_col_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd || stb.wr) |-> bankOpen[stb.bank]);
  // R6: activate only to a closed bank
  p_act_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |-> !bankOpen[stb.bank]);
  // R9: refresh only with every bank closed
  p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.refr |-> (bankOpen == '0));
endmodule

// File: rtl/sched_ctrl.sv
`timescale 1ns/1ps
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 11,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h0043
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqAll,
  input  logic [NBANK-1:0]  bankOpen,
  input  logic [NBANK-1:0]  rowHit,
  input  logic [NBANK-1:0]  colOk,
  input  logic [NBANK-1:0]  preOk,
  input  logic [NBANK-1:0]  actOk,
  input  logic              rrdOk,
  input  logic              refDue,
  output strobe_t           stb,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr
);
  logic initDone, wantRefReq, allPreOk;
  logic [ROW_W-1:0] nxtAddr;

  function automatic logic [ROW_W-1:0] colAddr(input logic [COL_W-1:0] c);
    logic [ROW_W-1:0] a;
    a = '0;
    a[9:0] = c[9:0];
    a[COL_W:11] = c[COL_W-1:10];
    return a;
  endfunction

  always_comb begin
    stb        = '0;
    stb.bank   = reqBank;
    reqReady   = 1'b0;
    wantRefReq = reqValid && (reqOp == OP_REF);
    allPreOk   = &(preOk | ~bankOpen);
    if (!initDone) begin
      stb.mrs = 1'b1;
    end else if (refDue || wantRefReq) begin
      if (|bankOpen) begin
        if (allPreOk) begin stb.pre = 1'b1; stb.preAll = 1'b1; end
      end else if (&actOk) begin
        stb.refr = 1'b1;
        reqReady = wantRefReq;
      end
    end else if (reqValid) begin
      case (reqOp)
        OP_PRE: begin
          if (reqAll) begin
            if (allPreOk) begin stb.pre = 1'b1; stb.preAll = 1'b1; reqReady = 1'b1; end
          end else if (preOk[reqBank]) begin
            stb.pre = 1'b1; reqReady = 1'b1;
          end
        end
        OP_RD, OP_WR: begin
          if (rowHit[reqBank]) begin
            if (colOk[reqBank]) begin
              stb.rd = (reqOp == OP_RD);
              stb.wr = (reqOp == OP_WR);
              reqReady = 1'b1;
            end
          end else if (bankOpen[reqBank]) begin
            if (preOk[reqBank]) stb.pre = 1'b1;
          end else if (actOk[reqBank] && rrdOk) begin
            stb.act = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nxtAddr = '0;
    if (stb.mrs)                nxtAddr = MODE_WORD;
    else if (stb.act)           nxtAddr = reqRow;
    else if (stb.rd || stb.wr)  nxtAddr = colAddr(reqCol);
    else if (stb.pre)           nxtAddr[10] = stb.preAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initDone <= 1'b0;
      csN <= 1'b1; rasN <= 1'b1; casN <= 1'b1; weN <= 1'b1;
      ba <= '0; addr <= '0;
    end else begin
      initDone <= 1'b1;
      csN  <= !(stb.act || stb.rd || stb.wr || stb.pre || stb.refr || stb.mrs);
      rasN <= !(stb.act || stb.pre || stb.refr || stb.mrs);
      casN <= !(stb.rd || stb.wr || stb.refr || stb.mrs);
      weN  <= !(stb.wr || stb.pre || stb.mrs);
      ba   <= (stb.act || stb.rd || stb.wr || stb.pre) ? {stb.bank[0], stb.bank[1]} : '0;
      addr <= nxtAddr;
    end
  end

  // R2: at most one command decided per clock
  p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.act, stb.rd, stb.wr, stb.pre, stb.refr, stb.mrs}));
  // R1: the mode load is the very first command after reset
  p_mrs_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.mrs |-> (csN && rasN && casN && weN));
endmodule

// File: rtl/sdram_cmd_sched.sv
`timescale 1ns/1ps
module sdram_cmd_sched
  import sched_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 11,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_RRD   = 2,
  parameter int T_WR    = 1,
  parameter int T_MRD   = 1,
  parameter int REF_INT = 1039,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h0043
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqBank,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             reqAll,
  output logic             csN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [1:0]       ba,
  output logic [ROW_W-1:0] addr
);
  strobe_t stb;
  logic [NBANK-1:0] bankOpen, rowHit, colOk, preOk, actOk;
  logic rrdOk, refDue;

  sched_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .MODE_WORD(MODE_WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqAll(reqAll),
    .bankOpen(bankOpen), .rowHit(rowHit), .colOk(colOk), .preOk(preOk), .actOk(actOk),
    .rrdOk(rrdOk), .refDue(refDue), .stb(stb), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr));

  sched_bank_timers #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR), .T_MRD(T_MRD), .REF_INT(REF_INT)) u_timers (
    .clk(clk), .rstN(rstN), .stb(stb), .reqRow(reqRow), .bankOpen(bankOpen),
    .rowHit(rowHit), .colOk(colOk), .preOk(preOk), .actOk(actOk), .rrdOk(rrdOk),
    .refDue(refDue));
endmodule

// File: tb/sim_sdram_cmd_sched.sv
`timescale 1ns/1ps
module sim_sdram_cmd_sched;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 9, T_RRD = 2, T_WR = 1, T_MRD = 1;
  localparam int REF_T = 2000;
  localparam logic [12:0] MODE = 13'h0043;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqAll = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'd0, reqBank = 2'd0;
  logic [12:0] reqRow = '0;
  logic [10:0] reqCol = '0;
  logic csN, rasN, casN, weN;
  logic [1:0] ba;
  logic [12:0] addr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  sdram_cmd_sched #(.REF_INT(REF_T), .MODE_WORD(MODE)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .reqAll(reqAll),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // command log built from the pins
  int lastAct[4], lastPre[4], lastWr[4], actCnt[4], preCnt[4];
  logic [12:0] actRow[4];
  bit [3:0] openB = '0;
  int lastAnyAct = -1000, lastActBank = -1, lastRef = -1000, lastMrs = -1000;
  int lastCol = -1000, prevCol = -1000, refCount = 0, preAllCnt = 0;
  int firstKind = -1, firstAddr = -1;
  bit lastPreA10 = 1'b0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      lastAct[i] = -1000; lastPre[i] = -1000; lastWr[i] = -1000;
      actCnt[i] = 0; preCnt[i] = 0; actRow[i] = '0;
    end
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      if (rstN && !csN) begin
        automatic int b = {ba[0], ba[1]};
        automatic logic [2:0] k = {rasN, casN, weN};
        if (firstKind < 0) begin firstKind = k; firstAddr = addr; end
        case (k)
          3'b011: begin
            chk(cyc - lastPre[b] >= T_RP, "R7 pre->act", cyc - lastPre[b], T_RP);
            chk(cyc - lastAct[b] >= T_RC, "R7 act->act", cyc - lastAct[b], T_RC);
            if (lastActBank != b)
              chk(cyc - lastAnyAct >= T_RRD, "R8 act->act other bank", cyc - lastAnyAct, T_RRD);
            chk(cyc - lastRef >= T_RC, "R8 ref->act", cyc - lastRef, T_RC);
            chk(cyc - lastMrs >= T_MRD, "R1 mode->act", cyc - lastMrs, T_MRD);
            lastAct[b] = cyc; lastAnyAct = cyc; lastActBank = b;
            openB[b] = 1'b1; actRow[b] = addr; actCnt[b]++;
          end
          3'b101, 3'b100: begin
            chk(openB[b], "R6 column to open bank", openB[b], 1);
            chk(cyc - lastAct[b] >= T_RCD, "R7 act->col", cyc - lastAct[b], T_RCD);
            prevCol = lastCol; lastCol = cyc;
            if (k == 3'b100) lastWr[b] = cyc;
          end
          3'b010: begin
            lastPreA10 = addr[10];
            if (addr[10]) preAllCnt++; else preCnt[b]++;
            for (int i = 0; i < 4; i++) begin
              if (addr[10] || i == b) begin
                if (openB[i]) begin
                  chk(cyc - lastAct[i] >= T_RAS, "R7 act->pre", cyc - lastAct[i], T_RAS);
                  chk(cyc - lastWr[i] >= T_WR, "R7 wr->pre", cyc - lastWr[i], T_WR);
                end
                openB[i] = 1'b0; lastPre[i] = cyc;
              end
            end
          end
          3'b001: begin
            chk(openB == 4'b0, "R9 refresh with banks closed", openB, 0);
            chk(cyc - lastRef >= T_RC, "R8 ref->ref", cyc - lastRef, T_RC);
            if (refCount > 0)
              chk(cyc - lastRef <= REF_T + 20, "R9 refresh gap", cyc - lastRef, REF_T + 20);
            lastRef = cyc; refCount++;
          end
          3'b000: lastMrs = cyc;
          default: chk(1'b0, "R2 unknown command", k, 0);
        endcase
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [1:0] bank, input logic [12:0] row,
                      input logic [10:0] col, input logic all);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBank = bank; reqRow = row; reqCol = col; reqAll = all;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset;
    chk(csN && rasN && casN && weN, "R2 pins idle in reset", {csN, rasN, casN, weN}, 15);
    @(negedge clk); rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(firstKind == 0, "R1 first command is mode load", firstKind, 0);
    chk(firstAddr == MODE, "R1 mode word", firstAddr, MODE);
    chk(csN == 1'b1, "R2 deselect when idle", csN, 1);
  endtask

  task automatic t_closed_read;
    automatic int a0 = actCnt[2];
    send(2'd0, 2'd2, 13'h1ABC, 11'h5A5, 1'b0);
    chk({csN, rasN, casN, weN} == 4'b0101, "R2 read encoding", {csN, rasN, casN, weN}, 5);
    chk(ba == 2'b01, "R3 bank 2 pins", ba, 1);
    chk(addr == 13'h09A5, "R4 column mapping", addr, 13'h09A5);
    chk(actRow[2] == 13'h1ABC, "R4 activate row", actRow[2], 13'h1ABC);
    chk(actCnt[2] == a0 + 1, "R6 closed bank activates once", actCnt[2], a0 + 1);
  endtask

  task automatic t_hit_write;
    automatic int a0 = actCnt[2], p0 = preCnt[2] + preAllCnt;
    send(2'd1, 2'd2, 13'h1ABC, 11'h003, 1'b0);
    chk({csN, rasN, casN, weN} == 4'b0100, "R2 write encoding", {csN, rasN, casN, weN}, 4);
    chk(addr == 13'h0003, "R4 write column", addr, 3);
    chk(actCnt[2] == a0, "R5 hit needs no activate", actCnt[2], a0);
    chk(preCnt[2] + preAllCnt == p0, "R5 hit needs no precharge", preCnt[2] + preAllCnt, p0);
  endtask

  task automatic t_miss;
    automatic int p0 = preCnt[2];
    send(2'd0, 2'd2, 13'h0123, 11'h7FF, 1'b0);
    chk(preCnt[2] == p0 + 1, "R6 miss precharges the bank", preCnt[2], p0 + 1);
    chk(lastPreA10 == 1'b0, "R6 miss precharge is single-bank", lastPreA10, 0);
    chk(actRow[2] == 13'h0123, "R6 new row activated", actRow[2], 13'h0123);
    chk(addr == 13'h0BFF, "R4 column top bit on A11", addr, 13'h0BFF);
  endtask

  task automatic t_bank_map;
    send(2'd0, 2'd1, 13'h0005, 11'h000, 1'b0);
    chk(ba == 2'b10, "R3 bank 1 pins", ba, 2);
    send(2'd0, 2'd0, 13'h0100, 11'h010, 1'b0);
    chk(ba == 2'b00, "R3 bank 0 pins", ba, 0);
    send(2'd0, 2'd3, 13'h0777, 11'h020, 1'b0);
    chk(ba == 2'b11, "R3 bank 3 pins", ba, 3);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqBank = 2'd1; reqRow = 13'h0005; reqCol = 11'h001; reqAll = 1'b0;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqCol = 11'h002;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid = 1'b0;
    chk(lastCol - prevCol == 1, "R13 column commands on consecutive clocks", lastCol - prevCol, 1);
  endtask

  task automatic t_pre_single;
    automatic int a0 = actCnt[2];
    send(2'd2, 2'd1, 13'h0000, 11'h000, 1'b0);
    chk({csN, rasN, casN, weN} == 4'b0010, "R11 precharge encoding", {csN, rasN, casN, weN}, 2);
    chk(addr[10] == 1'b0, "R11 single precharge A10 low", addr[10], 0);
    chk(ba == 2'b10, "R11 precharged bank 1", ba, 2);
    send(2'd0, 2'd2, 13'h0123, 11'h004, 1'b0);
    chk(actCnt[2] == a0, "R11 other bank still open", actCnt[2], a0);
  endtask

  task automatic t_pre_all;
    automatic int a0 = actCnt[3];
    send(2'd2, 2'd0, 13'h0000, 11'h000, 1'b1);
    chk(addr[10] == 1'b1, "R11 precharge-all A10 high", addr[10], 1);
    send(2'd0, 2'd3, 13'h0777, 11'h005, 1'b0);
    chk(actCnt[3] == a0 + 1, "R11 bank reopened after precharge-all", actCnt[3], a0 + 1);
  endtask

  task automatic t_ref_req;
    automatic int pa0 = preAllCnt, r0 = refCount;
    send(2'd3, 2'd0, 13'h0000, 11'h000, 1'b0);
    chk({csN, rasN, casN, weN} == 4'b0001, "R12 refresh encoding", {csN, rasN, casN, weN}, 1);
    chk(preAllCnt == pa0 + 1, "R12 precharge-all before refresh", preAllCnt, pa0 + 1);
    chk(refCount == r0 + 1, "R12 one refresh issued", refCount, r0 + 1);
  endtask

  task automatic t_ref_periodic;
    automatic int r0 = refCount;
    repeat (3 * REF_T + 100) @(negedge clk);
    chk(refCount - r0 >= 3, "R9 periodic refresh count", refCount - r0, 3);
  endtask

  task automatic t_stress;
    automatic int r0 = refCount;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqBank = 2'd0; reqRow = 13'h0055; reqCol = 11'h004; reqAll = 1'b0;
    repeat (3 * REF_T + 100) @(negedge clk);
    reqValid = 1'b0;
    chk(refCount - r0 >= 3, "R10 refresh under read traffic", refCount - r0, 3);
    chk(lastCol > lastRef, "R10 reads continue after refresh", lastCol, lastRef);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_closed_read();
    t_hit_write();
    t_miss();
    t_bank_map();
    t_back_to_back();
    t_pre_single();
    t_pre_all();
    t_ref_req();
    t_ref_periodic();
    t_stress();
    repeat (20) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule